// File: doc/BRIEF.md
# Row-Bounded Page Write Controller

This block sits between a serial-bus slave front end and a byte-wide memory array. The front end reports bus events to it: a Start, the loaded two-byte start address, each received data byte, and each Stop together with the bit-slot number in which the Stop arrived. The block collects the data bytes of one write transaction into a one-row buffer and keeps a per-byte valid mask. It answers each data byte with acknowledge or no-acknowledge, depending on the write-control input.

When a Stop arrives in the slot directly after an acknowledge bit, the block runs a timed internal write cycle. During that cycle it drives every buffered byte into the array, one byte per clock, in ascending order of offset within the row. Busy stays high for the whole cycle, and every bus event is ignored until the cycle ends. After a committed write, the block's address pointer holds the address one past the last byte that was modified.

Top module: `page_write_ctrl`

## Requirements
- R1: After reset, busy_o, mem_we_o and ack_vld_o are low and addr_ptr_o is zero.
- R2: Data bytes are buffered at consecutive in-row offsets, starting at the low OFFW bits of the loaded address. During the commit, the array sees one write per clock in ascending offset order from the first busy cycle on, at address {row, offset}.
- R3: Only the low in-row offset bits advance, so the offset wraps from ROW_BYTES-1 to 0 inside the same row. A later byte at an offset already used replaces the earlier byte.
- R4: If wctl_i is high in any cycle from the Start pulse through the addr_load_i cycle, then every data byte is answered with ack_vld_o high and ack_o low, no write cycle runs, and the array is not written.
- R5: When writes are enabled, ack_vld_o pulses with ack_o high in the cycle after each data byte. A change of wctl_i after the address load has no effect.
- R6: A write cycle starts only on a Stop with stop_slot_i equal to 10 (the slot right after an acknowledge), and only if at least one byte was accepted. A Stop in any other slot discards the pending write.
- R7: busy_o rises in the cycle after the committing Stop and stays high for exactly WCYC clock cycles.
- R8: While busy_o is high, start, address, data and stop events are ignored: there is no acknowledge, the commit is not disturbed, and the pointer is not changed.
- R9: Only buffer offsets received in the current transaction are written. The valid mask clears at every Start, including a repeated Start.
- R10: addr_ptr_o takes the full loaded address at the address load. After a write cycle it holds ({row, last written offset} + 1) modulo 2^AW.
- R11: A single data byte followed by a committing Stop writes exactly that one location.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start or repeated Start seen on the bus (one-cycle pulse) |
| wctl_i | input | 1 | Write-control level; high inhibits writing |
| addr_load_i | input | 1 | Both address bytes received (one-cycle pulse) |
| addr_i | input | AW | Loaded start address |
| data_vld_i | input | 1 | Data byte received (one-cycle pulse) |
| data_i | input | 8 | Received data byte |
| stop_i | input | 1 | Stop seen on the bus (one-cycle pulse) |
| stop_slot_i | input | 4 | Bit slot in which the Stop arrived; 10 means right after an acknowledge |
| ack_vld_o | output | 1 | An answer for the last data byte is available |
| ack_o | output | 1 | 1 = acknowledge, 0 = no-acknowledge |
| busy_o | output | 1 | Internal write cycle in progress |
| mem_we_o | output | 1 | Array write strobe |
| mem_addr_o | output | AW | Array write address |
| mem_wdata_o | output | 8 | Array write data |
| addr_ptr_o | output | AW | Internal address pointer |

## Verification
Properties in the RTL are checked on every cycle. They cover the following: array writes happen only while busy, no acknowledge comes out during busy, busy rises only after a Stop in slot 10, and the busy timer holds busy until its last count and then drops it. The remaining behaviour can only be shown by the bench scenarios, because it depends on transaction history. That includes the in-row rollover with overwrite, the write-control window closing at the address load, the mask clearing on a repeated Start, the exact busy length, and the pointer value after a commit.

// File: rtl/pgw_pkg.sv
package pgw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ADDR  = 2'd1,
    ST_DATA  = 2'd2,
    ST_CYCLE = 2'd3
  } pgw_state_e;

  // slot number meaning "directly after the acknowledge bit"
  localparam logic [3:0] COMMIT_SLOT = 4'd10;
endpackage

// File: rtl/pgw_buffer.sv
module pgw_buffer #(
  parameter int ROW_BYTES = 64,
  localparam int OFFW = $clog2(ROW_BYTES)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr_i,
  input  logic            wr_i,
  input  logic [OFFW-1:0] wr_off_i,
  input  logic [7:0]      wr_data_i,
  input  logic [OFFW-1:0] rd_off_i,
  output logic [7:0]      rd_data_o,
  output logic            rd_vld_o
);
  logic [7:0] slot_data [ROW_BYTES];
  logic       slot_vld  [ROW_BYTES];

  for (genvar g = 0; g < ROW_BYTES; g++) begin : g_slot
    logic hit;
    assign hit = wr_i && (wr_off_i == OFFW'(g));

    always_ff @(posedge clk) begin
      if (hit) slot_data[g] <= wr_data_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     slot_vld[g] <= 1'b0;
      else if (clr_i) slot_vld[g] <= 1'b0;
      else if (hit)   slot_vld[g] <= 1'b1;
    end
  end

  assign rd_data_o = slot_data[rd_off_i];
  assign rd_vld_o  = slot_vld[rd_off_i];
endmodule

// File: rtl/pgw_timer.sv
module pgw_timer #(
  parameter int WCYC = 80,
  localparam int CW = $clog2(WCYC + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go_i,
  output logic          busy_o,
  output logic [CW-1:0] cnt_o,
  output logic          done_o
);
  logic          busy_q, busy_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          last;

  assign last = busy_q && (cnt_q == CW'(WCYC - 1));

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    if (go_i && !busy_q) begin
      busy_d = 1'b1;
      cnt_d  = '0;
    end else if (busy_q) begin
      if (last) busy_d = 1'b0;
      else      cnt_d  = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end

  assign busy_o = busy_q;
  assign cnt_o  = cnt_q;
  assign done_o = last;

  // R7
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && (cnt_q != CW'(WCYC - 1))) |=> busy_q);
  // R7
  busy_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && (cnt_q == CW'(WCYC - 1))) |=> !busy_q);
endmodule

// File: rtl/pgw_addr.sv
module pgw_addr #(
  parameter int AW = 16,
  parameter int OFFW = 6,
  localparam int RW = AW - OFFW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_i,
  input  logic [AW-1:0]   addr_i,
  input  logic            step_i,
  input  logic            fin_i,
  output logic [RW-1:0]   row_o,
  output logic [OFFW-1:0] off_o,
  output logic [AW-1:0]   ptr_o
);
  logic [RW-1:0]   row_q, row_d;
  logic [OFFW-1:0] off_q, off_d;
  logic [OFFW-1:0] last_q, last_d;
  logic [AW-1:0]   ptr_q, ptr_d;

  always_comb begin
    row_d  = row_q;
    off_d  = off_q;
    last_d = last_q;
    ptr_d  = ptr_q;
    if (load_i) begin
      row_d = addr_i[AW-1:OFFW];
      off_d = addr_i[OFFW-1:0];
      ptr_d = addr_i;
    end else if (step_i) begin
      last_d = off_q;
      off_d  = off_q + OFFW'(1);
    end else if (fin_i) begin
      ptr_d = {row_q, last_q} + AW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q  <= '0;
      off_q  <= '0;
      last_q <= '0;
      ptr_q  <= '0;
    end else begin
      row_q  <= row_d;
      off_q  <= off_d;
      last_q <= last_d;
      ptr_q  <= ptr_d;
    end
  end

  assign row_o = row_q;
  assign off_o = off_q;
  assign ptr_o = ptr_q;
endmodule

// File: rtl/page_write_ctrl.sv
module page_write_ctrl #(
  parameter int AW = 16,
  parameter int ROW_BYTES = 64,
  parameter int WCYC = 80,
  localparam int OFFW = $clog2(ROW_BYTES),
  localparam int RW = AW - OFFW,
  localparam int CW = $clog2(WCYC + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          wctl_i,
  input  logic          addr_load_i,
  input  logic [AW-1:0] addr_i,
  input  logic          data_vld_i,
  input  logic [7:0]    data_i,
  input  logic          stop_i,
  input  logic [3:0]    stop_slot_i,
  output logic          ack_vld_o,
  output logic          ack_o,
  output logic          busy_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [7:0]    mem_wdata_o,
  output logic [AW-1:0] addr_ptr_o
);
  import pgw_pkg::*;

  pgw_state_e state_q, state_d;
  logic inh_q, inh_d;
  logic any_q, any_d;
  logic ackv_q, ackv_d, ack_q, ack_d;
  logic clr, load, step, go, fin, accept;

  logic [RW-1:0]   row;
  logic [OFFW-1:0] off;
  logic [CW-1:0]   cnt;
  logic            done, tbusy;
  logic [7:0]      rd_data;
  logic            rd_vld;

  always_comb begin
    state_d = state_q;
    inh_d   = inh_q;
    any_d   = any_q;
    clr = 1'b0; load = 1'b0; step = 1'b0;
    go  = 1'b0; fin  = 1'b0; accept = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d = ST_ADDR; inh_d = wctl_i; any_d = 1'b0; clr = 1'b1;
        end
      end
      ST_ADDR: begin
        inh_d = inh_q | wctl_i;
        if (start_i) begin
          inh_d = wctl_i; any_d = 1'b0; clr = 1'b1;
        end else if (stop_i) begin
          state_d = ST_IDLE;
        end else if (addr_load_i) begin
          state_d = ST_DATA; load = 1'b1;
        end
      end
      ST_DATA: begin
        if (start_i) begin
          state_d = ST_ADDR; inh_d = wctl_i; any_d = 1'b0; clr = 1'b1;
        end else if (stop_i) begin
          if ((stop_slot_i == COMMIT_SLOT) && any_q && !inh_q) begin
            state_d = ST_CYCLE; go = 1'b1;
          end else begin
            state_d = ST_IDLE;
          end
        end else if (data_vld_i) begin
          accept = 1'b1;
          if (!inh_q) begin
            step = 1'b1; any_d = 1'b1;
          end
        end
      end
      ST_CYCLE: begin
        if (done) begin
          state_d = ST_IDLE; fin = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
    ackv_d = accept;
    ack_d  = accept ? !inh_q : ack_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      inh_q   <= 1'b0;
      any_q   <= 1'b0;
      ackv_q  <= 1'b0;
      ack_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      inh_q   <= inh_d;
      any_q   <= any_d;
      ackv_q  <= ackv_d;
      ack_q   <= ack_d;
    end
  end

  pgw_addr #(.AW(AW), .OFFW(OFFW)) u_addr (
    .clk(clk), .rst_n(rst_n), .load_i(load), .addr_i(addr_i),
    .step_i(step), .fin_i(fin), .row_o(row), .off_o(off), .ptr_o(addr_ptr_o)
  );

  pgw_buffer #(.ROW_BYTES(ROW_BYTES)) u_buf (
    .clk(clk), .rst_n(rst_n), .clr_i(clr), .wr_i(step), .wr_off_i(off),
    .wr_data_i(data_i), .rd_off_i(cnt[OFFW-1:0]), .rd_data_o(rd_data),
    .rd_vld_o(rd_vld)
  );

  pgw_timer #(.WCYC(WCYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .go_i(go), .busy_o(tbusy), .cnt_o(cnt),
    .done_o(done)
  );

  assign busy_o      = tbusy;
  assign ack_vld_o   = ackv_q;
  assign ack_o       = ack_q;
  assign mem_we_o    = tbusy && (int'(cnt) < ROW_BYTES) && rd_vld;
  assign mem_addr_o  = {row, cnt[OFFW-1:0]};
  assign mem_wdata_o = rd_data;

  // R2
  write_in_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |-> busy_o);
  // R8
  no_ack_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_vld_o |-> !busy_o);
  // R6
  commit_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> ($past(stop_i) && ($past(stop_slot_i) == COMMIT_SLOT)));
  // R8
  ptr_hold_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> $stable(addr_ptr_o));
endmodule

// File: tb/page_write_ctrl_test.sv
module page_write_ctrl_test;
  localparam int AW = 16;
  localparam int ROW = 64;
  localparam int OFFW = 6;
  localparam int WCYC = 80;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start_i = 0, wctl_i = 0, addr_load_i = 0, data_vld_i = 0, stop_i = 0;
  logic [AW-1:0] addr_i = '0;
  logic [7:0] data_i = '0;
  logic [3:0] stop_slot_i = '0;
  logic ack_vld_o, ack_o, busy_o, mem_we_o;
  logic [AW-1:0] mem_addr_o, addr_ptr_o;
  logic [7:0] mem_wdata_o;

  page_write_ctrl #(.AW(AW), .ROW_BYTES(ROW), .WCYC(WCYC)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .wctl_i(wctl_i),
    .addr_load_i(addr_load_i), .addr_i(addr_i), .data_vld_i(data_vld_i),
    .data_i(data_i), .stop_i(stop_i), .stop_slot_i(stop_slot_i),
    .ack_vld_o(ack_vld_o), .ack_o(ack_o), .busy_o(busy_o),
    .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
    .addr_ptr_o(addr_ptr_o)
  );

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard queues
  logic [AW+7:0] wr_q[$];
  bit ack_q[$];

  // reference model state
  logic [7:0] m_data [ROW];
  bit m_vld [ROW];
  logic [AW-OFFW-1:0] m_row;
  logic [OFFW-1:0] m_off, m_last;
  bit m_inh, m_any;
  logic [AW-1:0] m_ptr;

  // monitor
  int busy_run = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_we_o) begin
        if (wr_q.size() == 0) chk(0, "R9 unexpected write", {mem_addr_o, mem_wdata_o}, 0);
        else begin
          logic [AW+7:0] e;
          e = wr_q.pop_front();
          chk({mem_addr_o, mem_wdata_o} == e, "R2/R3 write", {mem_addr_o, mem_wdata_o}, e);
        end
      end
      if (ack_vld_o) begin
        if (ack_q.size() == 0) chk(0, "R8 unexpected ack", ack_o, 0);
        else begin
          bit ea;
          ea = ack_q.pop_front();
          chk(ack_o == ea, "R4/R5 ack", ack_o, ea);
        end
      end
      if (busy_o) busy_run++;
      else if (busy_run != 0) begin
        chk(busy_run == WCYC, "R7 busy length", busy_run, WCYC);
        busy_run = 0;
      end
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic do_start();
    tick(); start_i = 1;
    for (int i = 0; i < ROW; i++) m_vld[i] = 0;
    m_inh = wctl_i; m_any = 0;
    tick(); start_i = 0;
  endtask

  task automatic do_load(input logic [AW-1:0] a);
    tick(); addr_load_i = 1; addr_i = a;
    m_inh = m_inh | wctl_i;
    m_row = a[AW-1:OFFW]; m_off = a[OFFW-1:0]; m_ptr = a;
    tick(); addr_load_i = 0;
  endtask

  task automatic do_byte(input logic [7:0] d);
    tick(); data_vld_i = 1; data_i = d;
    ack_q.push_back(!m_inh);
    if (!m_inh) begin
      m_data[m_off] = d; m_vld[m_off] = 1; m_last = m_off;
      m_off = m_off + 1'b1; m_any = 1;
    end
    tick(); data_vld_i = 0;
  endtask

  task automatic do_stop(input logic [3:0] slot, input string req);
    bit commit;
    commit = (slot == 4'd10) && m_any && !m_inh;
    if (commit) begin
      for (int i = 0; i < ROW; i++)
        if (m_vld[i]) wr_q.push_back({m_row, OFFW'(i), m_data[i]});
    end
    tick(); stop_i = 1; stop_slot_i = slot;
    tick(); stop_i = 0;
    @(negedge clk);
    chk(busy_o == commit, {req, " busy after stop"}, busy_o, commit);
    if (commit) m_ptr = {m_row, m_last} + 1'b1;
  endtask

  task automatic settle(input string req);
    repeat (WCYC + 3) @(posedge clk);
    @(negedge clk);
    chk(!busy_o, {req, " idle"}, busy_o, 0);
    chk(wr_q.size() == 0, {req, " all writes seen"}, wr_q.size(), 0);
    chk(ack_q.size() == 0, {req, " all acks seen"}, ack_q.size(), 0);
    chk(addr_ptr_o == m_ptr, "R10 pointer", addr_ptr_o, m_ptr);
  endtask

  initial begin
    m_ptr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk(!busy_o && !mem_we_o && !ack_vld_o, "R1 reset outputs", {busy_o, mem_we_o, ack_vld_o}, 0);
    chk(addr_ptr_o == 0, "R1 reset pointer", addr_ptr_o, 0);
    rst_n = 1;

    // R2 R5 R10: four-byte page write
    do_start(); do_load(16'h0123);
    do_byte(8'hA1); do_byte(8'hB2); do_byte(8'hC3); do_byte(8'hD4);
    do_stop(4'd10, "R2");
    settle("R2");

    // R3 rollover with overwrite, pointer crosses row end
    do_start(); do_load(16'h0A3E);
    for (int i = 0; i < ROW + 2; i++) do_byte(8'(i + 8'h40));
    do_stop(4'd10, "R3");
    settle("R3");

    // R4 write control high during address phase
    do_start(); wctl_i = 1; tick(); m_inh = 1; wctl_i = 0;
    do_load(16'h0400);
    do_byte(8'h11); do_byte(8'h22);
    do_stop(4'd10, "R4");
    settle("R4");

    // R4 write control high at the address-load cycle itself
    do_start(); wctl_i = 1; do_load(16'h0440); wctl_i = 0;
    do_byte(8'h33);
    do_stop(4'd10, "R4 load cycle");
    settle("R4");

    // R5 write control raised after address load is ignored
    do_start(); do_load(16'h0500);
    wctl_i = 1;
    do_byte(8'h55); do_byte(8'h66);
    do_stop(4'd10, "R5");
    wctl_i = 0;
    settle("R5");

    // R6 stop in wrong slot discards
    do_start(); do_load(16'h0600);
    do_byte(8'h77);
    do_stop(4'd9, "R6 slot 9");
    settle("R6");

    // R6 no bytes, slot 10: nothing happens
    do_start(); do_load(16'h0680);
    do_stop(4'd10, "R6 empty");
    settle("R6");

    // R11 byte write, then R8 activity during busy
    do_start(); do_load(16'h07FF);
    do_byte(8'h9C);
    do_stop(4'd10, "R11");
    tick(); start_i = 1; tick(); start_i = 0;
    addr_load_i = 1; addr_i = 16'h5555; tick(); addr_load_i = 0;
    data_vld_i = 1; data_i = 8'hEE; tick(); data_vld_i = 0;
    stop_i = 1; stop_slot_i = 4'd10; tick(); stop_i = 0;
    @(negedge clk);
    chk(busy_o, "R8 still busy", busy_o, 1);
    settle("R8/R11");

    // R9 repeated start clears the mask
    do_start(); do_load(16'h0200);
    do_byte(8'h01); do_byte(8'h02); do_byte(8'h03);
    do_start(); do_load(16'h0210);
    do_byte(8'h04);
    do_stop(4'd10, "R9");
    settle("R9");

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule